// File: doc/BRIEF.md
# Calibrated ADC Code to Millivolt Converter

This block turns a raw 12-bit converter code into a voltage in millivolts. Each request names the raw code, a 5-bit channel number and a scale bit. The block picks one of two straight calibration lines, a low-range line or a high-range line. It interpolates between that line's two points and clamps a negative voltage to zero. For most channels it then scales the voltage by the attenuation ratio of that channel, rounding to the nearest integer. Both divisions share one multi-cycle restoring divider. The block accepts one request at a time and shows that it is busy by dropping `req_ready`.

Each line's two code points can be trimmed through a small configuration port. A write carries two trim bytes for one line. Every point is rebuilt from its byte and a fixed nominal code. Until the first trim write, each line uses a fixed uncalibrated pair of points.

The control is a six-state machine:
- `ST_IDLE` goes to `ST_PREP` when a request is accepted.
- `ST_PREP` starts the interpolation division and goes to `ST_DIV_LINE`.
- `ST_DIV_LINE` goes to `ST_SUM` when the divider finishes.
- `ST_SUM` goes straight to `ST_DONE` for channels that need no ratio. For all other channels it starts the ratio division and goes to `ST_DIV_RATIO`.
- `ST_DIV_RATIO` goes to `ST_DONE` when the divider finishes.
- `ST_DONE` holds the result and returns to `ST_IDLE` once `res_ready` is seen.

Top module: `adc_mv_converter`

## Requirements
- R1: After reset, `req_ready` is 1 and `res_valid` is 0. Until trimmed, the low-range line is (1000 mV, code 3413) and (100 mV, code 341), and the high-range line is (4200 mV, code 3310) and (3600 mV, code 2832).
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the result has been taken, on an edge with `res_valid` and `res_ready` both 1.
- R3: While `res_valid` is 1 and `res_ready` is 0, `res_valid` stays 1 and `res_mv` does not change.
- R4: Channel 1 returns the low-range interpolated voltage with no ratio applied.
- R5: Channel 5 returns the high-range interpolated voltage with no ratio applied. Every other channel interpolates on the low-range line.
- R6: A write with `cfg_valid`=1 and `cfg_line` selecting the line (0 = low range, 1 = high range) rebuilds both points of that line only. `cfg_trim[7:0]` sets the first point (the higher-voltage one) and `cfg_trim[15:8]` sets the second point. Each point is (byte + nominal − 128) × 4. The nominal codes are 833 and 80 for the low range, and 856 and 733 for the high range.
- R7: The interpolated voltage is v1 + (v0 − v1)·(raw − a1)/(a0 − a1), where the quotient is a signed division truncated toward zero. A negative voltage is returned as 0.
- R8: Ratio channels return volt × den / num:
  - channels 2–4 with scale bit 1: num 400, den 1025
  - channel 6: num 375, den 9000
  - channels 7–8 with scale bit 1: num 100, den 125
  - channel 19: num 1, den 3
- R9: The ratio step rounds to nearest by computing floor((volt × den + floor(num/2)) / num).
- R10: All other channels use num 1, den 1. This includes channels 2–4 and 7–8 with scale bit 0, channel 0, and channels 20–31. For these channels the result equals the interpolated voltage.
- R11: Let the accepting edge be edge 0. `res_valid` rises after edge DIV_W+3 for channels 1 and 5, and after edge 2·DIV_W+4 for all other channels.
- R12: When the two code points of the selected line are equal, the quotient term is taken as 0 and the voltage is v1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_code | input | 12 | Raw converter code |
| req_chan | input | 5 | Channel number |
| req_scale | input | 1 | Scale bit for the ratio choice |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_mv | output | DIV_W | Result in millivolts (unsigned) |
| cfg_valid | input | 1 | Trim write strobe |
| cfg_line | input | 1 | Target line: 0 = low range, 1 = high range |
| cfg_trim | input | 16 | Trim bytes: [7:0] first point, [15:8] second point |

## Verification
With the default DIV_W of 32, the result of channel 1 or 5 is due after edge 35 from acceptance, and the result of any other channel after edge 68.

The bench works out the expected due edge from the channel before it drives each request. It then counts edges from the accepting edge. At every falling edge in between it checks that `res_valid` is 0 and `req_ready` is 0, and that `res_valid` is 1 exactly at the due edge.

The result value is checked at that same falling edge. It is checked again while `res_ready` is held low, and the return to idle is checked one edge after the handshake.

// File: rtl/adc_mv_pkg.sv
package adc_mv_pkg;

    localparam int CODE_W    = 12;
    localparam int CHAN_W    = 5;
    localparam int TRIM_W    = 8;
    localparam int PT_W      = 16;
    localparam int RATIO_W   = 16;

    // line voltages in millivolts
    localparam int HI_V0     = 4200;
    localparam int HI_V1     = 3600;
    localparam int LO_V0     = 1000;
    localparam int LO_V1     = 100;

    // nominal codes used by the trim rebuild
    localparam int HI_NOM0   = 856;
    localparam int HI_NOM1   = 733;
    localparam int LO_NOM0   = 833;
    localparam int LO_NOM1   = 80;

    // untrimmed code points
    localparam int HI_DEF0   = 3310;
    localparam int HI_DEF1   = 2832;
    localparam int LO_DEF0   = 3413;
    localparam int LO_DEF1   = 341;

    localparam int TRIM_BIAS = 128;
    localparam int TRIM_GAIN = 4;

    typedef logic signed [PT_W-1:0] pt_t;

    typedef struct packed {
        pt_t a0;
        pt_t a1;
    } line_pts_t;

    typedef struct packed {
        logic [RATIO_W-1:0] num;
        logic [RATIO_W-1:0] den;
    } ratio_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_DIV_LINE,
        ST_SUM,
        ST_DIV_RATIO,
        ST_DONE
    } conv_state_t;

    function automatic pt_t trim_point(input logic [TRIM_W-1:0] b, input int nominal);
        int t;
        t = (int'(b) + nominal - TRIM_BIAS) * TRIM_GAIN;
        return pt_t'(t);
    endfunction

    function automatic int line_v0(input logic hi);
        return hi ? HI_V0 : LO_V0;
    endfunction

    function automatic int line_v1(input logic hi);
        return hi ? HI_V1 : LO_V1;
    endfunction

endpackage

// File: rtl/adc_mv_trim_store.sv
module adc_mv_trim_store
    import adc_mv_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_valid,
    input  logic                  cfg_line,
    input  logic [2*TRIM_W-1:0]   cfg_trim,
    output line_pts_t             lo_pts,
    output line_pts_t             hi_pts
);

    for (genvar g = 0; g < 2; g++) begin : g_line
        localparam logic SEL  = (g == 1);
        localparam int   NOM0 = (g == 1) ? HI_NOM0 : LO_NOM0;
        localparam int   NOM1 = (g == 1) ? HI_NOM1 : LO_NOM1;
        localparam int   DEF0 = (g == 1) ? HI_DEF0 : LO_DEF0;
        localparam int   DEF1 = (g == 1) ? HI_DEF1 : LO_DEF1;

        line_pts_t pts_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pts_q.a0 <= pt_t'(DEF0);
                pts_q.a1 <= pt_t'(DEF1);
            end else if (cfg_valid && (cfg_line == SEL)) begin
                pts_q.a0 <= trim_point(cfg_trim[TRIM_W-1:0], NOM0);
                pts_q.a1 <= trim_point(cfg_trim[2*TRIM_W-1:TRIM_W], NOM1);
            end
        end
    end

    assign lo_pts = g_line[0].pts_q;
    assign hi_pts = g_line[1].pts_q;

endmodule

// File: rtl/adc_mv_ratio_lut.sv
module adc_mv_ratio_lut
    import adc_mv_pkg::*;
(
    input  logic [CHAN_W-1:0] chan,
    input  logic              scale,
    output ratio_t            ratio
);

    always_comb begin
        ratio.num = RATIO_W'(1);
        ratio.den = RATIO_W'(1);
        case (chan)
            CHAN_W'(1), CHAN_W'(2), CHAN_W'(3), CHAN_W'(4): begin
                if (scale) begin
                    ratio.num = RATIO_W'(400);
                    ratio.den = RATIO_W'(1025);
                end
            end
            CHAN_W'(5): begin
                ratio.num = RATIO_W'(7);
                ratio.den = RATIO_W'(29);
            end
            CHAN_W'(6): begin
                ratio.num = RATIO_W'(375);
                ratio.den = RATIO_W'(9000);
            end
            CHAN_W'(7), CHAN_W'(8): begin
                if (scale) begin
                    ratio.num = RATIO_W'(100);
                    ratio.den = RATIO_W'(125);
                end
            end
            CHAN_W'(19): begin
                ratio.num = RATIO_W'(1);
                ratio.den = RATIO_W'(3);
            end
            default: begin
                ratio.num = RATIO_W'(1);
                ratio.den = RATIO_W'(1);
            end
        endcase
    end

endmodule

// File: rtl/adc_mv_restoring_div.sv
module adc_mv_restoring_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quot,
    output logic         done
);

    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     rem_q;
    logic [W-1:0]     quo_q;
    logic [W-1:0]     dvs_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    logic [W:0]       shifted;
    logic             fits;
    logic [W-1:0]     rem_next;
    logic [W-1:0]     quo_next;

    always_comb begin
        shifted  = {rem_q, quo_q[W-1]};
        fits     = (shifted >= {1'b0, dvs_q});
        rem_next = fits ? (shifted[W-1:0] - dvs_q) : shifted[W-1:0];
        quo_next = {quo_q[W-2:0], fits};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem_q  <= '0;
                quo_q  <= dividend;
                dvs_q  <= divisor;
                cnt_q  <= CNT_W'(W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q <= rem_next;
                quo_q <= quo_next;
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    assign quot = quo_q;

endmodule

// File: rtl/adc_mv_converter.sv
module adc_mv_converter
    import adc_mv_pkg::*;
#(
    parameter int DIV_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [CODE_W-1:0]   req_code,
    input  logic [CHAN_W-1:0]   req_chan,
    input  logic                req_scale,
    output logic                res_valid,
    input  logic                res_ready,
    output logic [DIV_W-1:0]    res_mv,
    input  logic                cfg_valid,
    input  logic                cfg_line,
    input  logic [2*TRIM_W-1:0] cfg_trim
);

    localparam int PAD_W = DIV_W - CODE_W;

    conv_state_t state_q, state_d;

    line_pts_t lo_pts, hi_pts;
    ratio_t    req_ratio;

    // captured request
    logic [CODE_W-1:0] code_q;
    logic              hi_q;
    logic              direct_q;
    pt_t               a0_q, a1_q;
    ratio_t            ratio_q;
    logic              neg_q, zero_q;
    logic [DIV_W-1:0]  quo_q;
    logic [DIV_W-1:0]  res_q;

    // arithmetic
    logic signed [DIV_W-1:0] span_s, offs_s, prod_s, dvsr_s;
    logic        [DIV_W-1:0] prod_mag, dvsr_mag;
    logic signed [DIV_W-1:0] q_s, sum_s;
    logic        [DIV_W-1:0] volt_u, ratio_dividend;

    // shared divider
    logic             div_start, div_done;
    logic [DIV_W-1:0] div_dividend, div_divisor, div_quot;

    logic accept;

    adc_mv_trim_store u_trim (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_valid (cfg_valid),
        .cfg_line  (cfg_line),
        .cfg_trim  (cfg_trim),
        .lo_pts    (lo_pts),
        .hi_pts    (hi_pts)
    );

    adc_mv_ratio_lut u_lut (
        .chan  (req_chan),
        .scale (req_scale),
        .ratio (req_ratio)
    );

    adc_mv_restoring_div #(.W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (div_dividend),
        .divisor  (div_divisor),
        .quot     (div_quot),
        .done     (div_done)
    );

    assign accept = (state_q == ST_IDLE) && req_valid;

    // interpolation operands and result
    always_comb begin
        span_s   = DIV_W'(line_v0(hi_q) - line_v1(hi_q));
        offs_s   = $signed({{PAD_W{1'b0}}, code_q}) - DIV_W'(a1_q);
        prod_s   = span_s * offs_s;
        dvsr_s   = DIV_W'(a0_q) - DIV_W'(a1_q);
        prod_mag = prod_s[DIV_W-1] ? DIV_W'(-prod_s) : prod_s;
        dvsr_mag = dvsr_s[DIV_W-1] ? DIV_W'(-dvsr_s) : dvsr_s;

        q_s   = neg_q ? -$signed(quo_q) : $signed(quo_q);
        sum_s = (zero_q ? '0 : q_s) + DIV_W'(line_v1(hi_q));
        volt_u = sum_s[DIV_W-1] ? '0 : sum_s;
        ratio_dividend = volt_u * DIV_W'(ratio_q.den) + DIV_W'(ratio_q.num >> 1);
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = ST_PREP;
            ST_PREP:      state_d = ST_DIV_LINE;
            ST_DIV_LINE:  if (div_done) state_d = ST_SUM;
            ST_SUM:       state_d = direct_q ? ST_DONE : ST_DIV_RATIO;
            ST_DIV_RATIO: if (div_done) state_d = ST_DONE;
            ST_DONE:      if (res_ready) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q   <= '0;
            hi_q     <= 1'b0;
            direct_q <= 1'b0;
            a0_q     <= '0;
            a1_q     <= '0;
            ratio_q  <= '0;
            neg_q    <= 1'b0;
            zero_q   <= 1'b0;
            quo_q    <= '0;
            res_q    <= '0;
        end else begin
            if (accept) begin
                code_q   <= req_code;
                hi_q     <= (req_chan == CHAN_W'(5));
                direct_q <= (req_chan == CHAN_W'(5)) || (req_chan == CHAN_W'(1));
                a0_q     <= (req_chan == CHAN_W'(5)) ? hi_pts.a0 : lo_pts.a0;
                a1_q     <= (req_chan == CHAN_W'(5)) ? hi_pts.a1 : lo_pts.a1;
                ratio_q  <= req_ratio;
            end
            if (state_q == ST_PREP) begin
                neg_q  <= prod_s[DIV_W-1] ^ dvsr_s[DIV_W-1];
                zero_q <= (dvsr_s == '0);
            end
            if ((state_q == ST_DIV_LINE) && div_done) quo_q <= div_quot;
            if ((state_q == ST_SUM) && direct_q)      res_q <= volt_u;
            if ((state_q == ST_DIV_RATIO) && div_done) res_q <= div_quot;
        end
    end

    // outputs
    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        res_valid    = (state_q == ST_DONE);
        div_start    = (state_q == ST_PREP) || ((state_q == ST_SUM) && !direct_q);
        div_dividend = (state_q == ST_PREP) ? prod_mag : ratio_dividend;
        div_divisor  = (state_q == ST_PREP) ? dvsr_mag : DIV_W'(ratio_q.num);
        res_mv       = res_q;
    end

endmodule

// File: rtl/adc_mv_converter_chk.sv
module adc_mv_converter_chk #(
    parameter int DIV_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             res_valid,
    input logic             res_ready,
    input logic [DIV_W-1:0] res_mv
);

    logic [15:0] since_q;
    logic        accept;

    assign accept = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                since_q <= '0;
        else if (accept)           since_q <= '0;
        else if (since_q != '1)    since_q <= since_q + 16'd1;
    end

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    assert_no_ready_with_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !req_ready);

    assert_result_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_mv)));

    assert_no_early_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !res_valid);

    assert_result_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> ((since_q == 16'(DIV_W + 3)) || (since_q == 16'(2 * DIV_W + 4))));

endmodule

bind adc_mv_converter adc_mv_converter_chk #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_mv    (res_mv)
);

// File: tb/adc_mv_converter_tb.sv
`timescale 1ns/1ps
module adc_mv_converter_tb;

    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [11:0]   req_code = '0;
    logic [4:0]    req_chan = '0;
    logic          req_scale = 1'b0;
    logic          res_valid;
    logic          res_ready = 1'b0;
    logic [W-1:0]  res_mv;
    logic          cfg_valid = 1'b0;
    logic          cfg_line = 1'b0;
    logic [15:0]   cfg_trim = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit finished = 1'b0;

    // model of the calibration points
    int lo_a0 = 3413, lo_a1 = 341, hi_a0 = 3310, hi_a1 = 2832;

    always #2 clk = ~clk;

    adc_mv_converter #(.DIV_W(W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_code  (req_code),
        .req_chan  (req_chan),
        .req_scale (req_scale),
        .res_valid (res_valid),
        .res_ready (res_ready),
        .res_mv    (res_mv),
        .cfg_valid (cfg_valid),
        .cfg_line  (cfg_line),
        .cfg_trim  (cfg_trim)
    );

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            summary();
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int model(input int code, input int chan, input bit scale);
        int a0, a1, v0, v1, d, q, v, num, den;
        if (chan == 5) begin a0 = hi_a0; a1 = hi_a1; v0 = 4200; v1 = 3600; end
        else           begin a0 = lo_a0; a1 = lo_a1; v0 = 1000; v1 = 100;  end
        d = a0 - a1;
        q = (d == 0) ? 0 : ((v0 - v1) * (code - a1)) / d;
        v = q + v1;
        if (v < 0) v = 0;
        if (chan == 1 || chan == 5) return v;
        num = 1; den = 1;
        if (chan >= 2 && chan <= 4 && scale) begin num = 400; den = 1025; end
        else if (chan == 6)                   begin num = 375; den = 9000; end
        else if ((chan == 7 || chan == 8) && scale) begin num = 100; den = 125; end
        else if (chan == 19)                  begin num = 1;   den = 3;    end
        return (v * den + num / 2) / num;
    endfunction

    task automatic load_trim(input bit hi, input int b0, input int b1);
        @(negedge clk);
        cfg_valid = 1'b1;
        cfg_line  = hi;
        cfg_trim  = {b1[7:0], b0[7:0]};
        @(posedge clk);
        @(negedge clk);
        cfg_valid = 1'b0;
        if (hi) begin hi_a0 = (b0 + 856 - 128) * 4; hi_a1 = (b1 + 733 - 128) * 4; end
        else    begin lo_a0 = (b0 + 833 - 128) * 4; lo_a1 = (b1 + 80 - 128) * 4;  end
    endtask

    task automatic run_req(input int code, input int chan, input bit scale,
                           input int hold, input string req);
        int  exp, lat;
        bit  seq_ok, busy_ok, hold_ok;
        exp = model(code, chan, scale);
        lat = (chan == 1 || chan == 5) ? W + 3 : 2 * W + 4;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_code  = 12'(code);
        req_chan  = 5'(chan);
        req_scale = scale;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        seq_ok  = 1'b1;
        busy_ok = 1'b1;
        for (int k = 1; k <= lat; k++) begin
            @(negedge clk);
            if (res_valid !== (k == lat)) seq_ok = 1'b0;
            if (req_ready !== 1'b0) busy_ok = 1'b0;
        end
        check(seq_ok, "R11", $sformatf("result timing ch%0d", chan), res_valid, 1);
        check(busy_ok, "R2", "ready low while busy", req_ready, 0);
        check(int'(res_mv) == exp, req,
              $sformatf("value code %0d ch%0d scale %0d", code, chan, scale),
              res_mv, exp);
        if (hold > 0) begin
            hold_ok = 1'b1;
            for (int k = 0; k < hold; k++) begin
                @(negedge clk);
                if (res_valid !== 1'b1 || int'(res_mv) != exp) hold_ok = 1'b0;
            end
            check(hold_ok, "R3", "result held while not taken", res_mv, exp);
        end
        res_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        res_ready = 1'b0;
        check(req_ready === 1'b1 && res_valid === 1'b0, "R2", "back to idle after take",
              req_ready, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(req_ready === 1'b1 && res_valid === 1'b0, "R1", "reset state", req_ready, 1);

        // untrimmed lines
        run_req(2000, 1, 1'b0, 0, "R1");
        run_req(0,    1, 1'b0, 0, "R4");
        run_req(4095, 1, 1'b1, 0, "R4");
        run_req(3000, 5, 1'b0, 0, "R5");
        run_req(2832, 5, 1'b1, 4, "R5");

        // ratio channels and rounding
        run_req(1500, 2,  1'b1, 0, "R8");
        run_req(2500, 2,  1'b1, 0, "R9");
        run_req(2600, 4,  1'b1, 0, "R9");
        run_req(1200, 6,  1'b0, 0, "R8");
        run_req(3000, 7,  1'b1, 0, "R8");
        run_req(2222, 19, 1'b0, 0, "R8");
        run_req(1500, 3,  1'b0, 0, "R10");
        run_req(3000, 8,  1'b0, 0, "R10");
        run_req(1800, 0,  1'b0, 0, "R10");
        run_req(1800, 20, 1'b1, 0, "R10");
        run_req(4000, 31, 1'b1, 2, "R10");

        // trimmed low-range line: negative voltage clamps
        load_trim(1'b0, 0, 255);
        run_req(0,    1, 1'b0, 0, "R7");
        run_req(3000, 2, 1'b1, 0, "R6");

        // trimmed high-range line: negative span, then coincident points
        load_trim(1'b1, 0, 255);
        run_req(4095, 5, 1'b0, 0, "R7");
        run_req(2000, 1, 1'b0, 0, "R6");
        load_trim(1'b1, 0, 123);
        run_req(1000, 5, 1'b0, 0, "R12");
        load_trim(1'b1, 128, 128);
        run_req(3100, 5, 1'b0, 0, "R6");
        load_trim(1'b0, 128, 128);
        run_req(500, 1, 1'b0, 0, "R6");

        finished = 1'b1;
        summary();
    end

endmodule